// File: doc/BRIEF.md
# Per-Channel Selectable Input Debouncer

This block cleans up a bank of slow digital inputs before they reach the input-data read path and the event-detection path of a larger I/O controller. Every channel has its own enable bit and its own 2-bit duration select. A disabled channel is a plain two-flop synchronizer. An enabled channel holds its filtered level until the synchronized raw input has stayed at a new level for the selected duration. Then the output takes that level.

To keep the per-channel counters narrow, timing is counted in ticks of one shared prescaler rather than in clock cycles. The four durations are parameters, given as a number of ticks. Because a channel's first tick can arrive anywhere inside a tick period, the real filtering time lies between (N-1)·P+1 and N·P cycles, where N is the selected tick count and P is the prescaler period. With N of at least 4, this is never more than nominal and never less than 75% of it.

A small byte-wide register file holds the enable and select bits. It is written and read through a simple synchronous write, combinational read port. After reset, every channel is disabled and every select is zero.

Top module: `chan_debounce`

## Requirements
- R1: After reset, all enable and duration-select bits read as zero and every filtered output is 0 while the raw inputs are 0.
- R2: Enable register j sits at address j (j from 0 to NUM_CH/8-1), and its bit b enables channel 8j+b (1 = debounce, 0 = bypass). Writes to unmapped addresses change nothing, and reads from them return 0.
- R3: Duration register k sits at address NUM_CH/8+k and holds four 2-bit selects: channel 4k+i uses bits [2i+1:2i]. Select values 0, 1, 2 and 3 pick TICKS0, TICKS1, TICKS2 and TICKS3.
- R4: A disabled channel's output equals its raw input delayed by exactly two clock edges.
- R5: For an enabled channel with select tick count N and prescaler period P, a raw change held steady is not yet visible on the output 2+(N-1)·P edges after it is applied. It is visible after 2+N·P edges. The state changes only on a tick.
- R6: On an enabled channel, a raw pulse lasting at most (N-2)·P cycles never reaches the output.
- R7: When the raw input returns to the output level, the channel's count clears. A later change then needs the full R5 time again, and the output only ever takes the synchronized raw value.
- R8: The shared prescaler asserts its tick for one cycle in every TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (31.25 MHz in the target system) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | NUM_CH | Unsynchronized raw inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| filt_o | output | NUM_CH | Filtered outputs to read and event paths |

## Verification
The bench builds the block with 8 channels, a tick every 4 cycles and durations of 4, 5, 6 and 8 ticks. At that scale every channel can be swept through every select value and both edge directions, with the early and late bounds of R5 checked on each transition. The short tick period keeps the glitch-rejection and count-restart cases to a few dozen cycles. The bench also sweeps bypass timing on all channels and reads back the register map, including an unmapped address.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic [1:0] {
    DUR_SEL0 = 2'd0,
    DUR_SEL1 = 2'd1,
    DUR_SEL2 = 2'd2,
    DUR_SEL3 = 2'd3
  } dur_sel_e;
endpackage

// File: rtl/dbnc_prescale.sv
module dbnc_prescale #(
  parameter int TICK_DIV = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      p_tick_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_CH-1:0]     en_o,
  output logic [2*NUM_CH-1:0]   sel_o
);
  localparam int EN_REGS  = NUM_CH / 8;
  localparam int DUR_REGS = NUM_CH / 4;
  localparam int N_REGS   = EN_REGS + DUR_REGS;

  logic [NUM_CH-1:0]   en_q;
  logic [2*NUM_CH-1:0] sel_q;

  for (genvar r = 0; r < EN_REGS; r++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               en_q[r*8 +: 8] <= '0;
      else if (we_i && addr_i == ADDR_W'(r))     en_q[r*8 +: 8] <= wdata_i;
    end
  end

  for (genvar r = 0; r < DUR_REGS; r++) begin : g_dur
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       sel_q[r*8 +: 8] <= '0;
      else if (we_i && addr_i == ADDR_W'(EN_REGS + r))   sel_q[r*8 +: 8] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < EN_REGS; r++)
      if (addr_i == ADDR_W'(r)) rdata_o = en_q[r*8 +: 8];
    for (int r = 0; r < DUR_REGS; r++)
      if (addr_i == ADDR_W'(EN_REGS + r)) rdata_o = sel_q[r*8 +: 8];
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  p_unmapped_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(addr_i) >= N_REGS) |=> ($stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan
  import dbnc_pkg::*;
#(
  parameter int TICKS0 = 4,
  parameter int TICKS1 = 64,
  parameter int TICKS2 = 1008,
  parameter int TICKS3 = 8065,
  parameter int CW     = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       filt_o
);
  logic [1:0]    sync_q;
  logic          s_w;
  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_w;

  assign s_w = sync_q[1];

  always_comb begin
    unique case (dur_sel_e'(sel_i))
      DUR_SEL0: lim_w = CW'(TICKS0);
      DUR_SEL1: lim_w = CW'(TICKS1);
      DUR_SEL2: lim_w = CW'(TICKS2);
      default:  lim_w = CW'(TICKS3);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!en_i) begin
        state_q <= s_w;              // track so enabling causes no glitch
        cnt_q   <= '0;
      end else if (s_w == state_q) begin
        cnt_q   <= '0;
      end else if (tick_i) begin
        if (cnt_q >= lim_w - 1'b1) begin  // >= covers a select shrunk mid-count
          state_q <= s_w;
          cnt_q   <= '0;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign filt_o = en_i ? state_q : s_w;

  p_flip_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && state_q != $past(state_q)) |-> $past(tick_i));

  p_flip_to_raw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> (state_q == $past(s_w)));

  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s_w == state_q) |=> (cnt_q == '0));
endmodule

// File: rtl/chan_debounce.sv
module chan_debounce #(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 4,
  parameter int TICK_DIV = 31,
  parameter int TICKS0   = 4,
  parameter int TICKS1   = 64,
  parameter int TICKS2   = 1008,
  parameter int TICKS3   = 8065
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [NUM_CH-1:0] filt_o
);
  localparam int MAX01 = (TICKS0 > TICKS1) ? TICKS0 : TICKS1;
  localparam int MAX23 = (TICKS2 > TICKS3) ? TICKS2 : TICKS3;
  localparam int MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CW    = $clog2(MAXT + 1);

  logic                tick_w;
  logic [NUM_CH-1:0]   en_w;
  logic [2*NUM_CH-1:0] sel_w;

  dbnc_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  dbnc_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en_w),
    .sel_o   (sel_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbnc_chan #(
      .TICKS0(TICKS0), .TICKS1(TICKS1), .TICKS2(TICKS2), .TICKS3(TICKS3), .CW(CW)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_i[c]),
      .en_i   (en_w[c]),
      .sel_i  (sel_w[2*c +: 2]),
      .tick_i (tick_w),
      .filt_o (filt_o[c])
    );
  end
endmodule

// File: tb/chan_debounce_bench.sv
module chan_debounce_bench;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int D   = 4;
  localparam int T0 = 4, T1 = 5, T2 = 6, T3 = 8;
  localparam int EN_REGS = NCH / 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] raw = '0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic [NCH-1:0] filt;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  chan_debounce #(
    .NUM_CH(NCH), .ADDR_W(AW), .TICK_DIV(D),
    .TICKS0(T0), .TICKS1(T1), .TICKS2(T2), .TICKS3(T3)
  ) u_chan_debounce (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .filt_o(filt)
  );

  function automatic int ticks_of(int s);
    case (s)
      0: return T0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = 8'(d); we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a);
    #1 d = int'(rdata);
  endtask

  task automatic setup_ch(input int ch, input int sel);
    wr(0, 0);
    wr(EN_REGS + ch / 4, sel << (2 * (ch % 4)));
    wr(0, 1 << ch);
    idle(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v;
    logic old;
    bit changed;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(a, v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(filt == '0, "R1 filt reset", int'(filt), 0);

    // R2/R3 readback and unmapped address
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hC9);
    wr(5, 8'hFF);
    rd(0, v); chk(v == 8'hA5, "R2 enable readback", v, 8'hA5);
    rd(1, v); chk(v == 8'h3C, "R3 duration readback reg1", v, 8'h3C);
    rd(2, v); chk(v == 8'hC9, "R3 duration readback reg2", v, 8'hC9);
    rd(5, v); chk(v == 0, "R2 unmapped read", v, 0);
    wr(0, 0); wr(1, 0); wr(2, 0);
    idle(4);

    // R4 bypass timing on every channel, both edges
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 2; k++) begin
        old = raw[ch];
        raw[ch] = ~old;
        idle(1);
        chk(filt[ch] == old, "R4 bypass not before 2 edges", int'(filt[ch]), int'(old));
        idle(1);
        chk(filt[ch] == ~old, "R4 bypass after 2 edges", int'(filt[ch]), int'(~old));
      end
    end

    // R5/R3/R2 sweep: every channel, select, direction
    for (int ch = 0; ch < NCH; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        n = ticks_of(sel);
        for (int k = 0; k < 2; k++) begin
          setup_ch(ch, sel);
          old = raw[ch];
          raw[ch] = ~old;
          idle(2 + (n - 1) * D);
          chk(filt[ch] == old, $sformatf("R5 early ch%0d sel%0d", ch, sel),
              int'(filt[ch]), int'(old));
          idle(D);
          chk(filt[ch] == ~old, $sformatf("R5 late ch%0d sel%0d", ch, sel),
              int'(filt[ch]), int'(~old));
        end
      end
    end

    // R6 glitch rejection
    setup_ch(2, 3);
    n = T3;
    old = raw[2];
    changed = 1'b0;
    raw[2] = ~old;
    for (int i = 0; i < (n - 2) * D; i++) begin
      idle(1);
      if (filt[2] != old) changed = 1'b1;
    end
    raw[2] = old;
    for (int i = 0; i < n * D + 6; i++) begin
      idle(1);
      if (filt[2] != old) changed = 1'b1;
    end
    chk(!changed, "R6 short pulse rejected", int'(changed), 0);

    // R7 count restart after return to output level
    setup_ch(5, 3);
    old = raw[5];
    raw[5] = ~old;
    idle((n - 2) * D);
    raw[5] = old;
    idle(2);
    raw[5] = ~old;
    idle(2 + (n - 1) * D);
    chk(filt[5] == old, "R7 restart needs full time", int'(filt[5]), int'(old));
    idle(D);
    chk(filt[5] == ~old, "R7 restart completes", int'(filt[5]), int'(~old));

    // R8 tick period seen through shortest select: bounds hold on another channel
    setup_ch(7, 0);
    old = raw[7];
    raw[7] = ~old;
    idle(2 + (T0 - 1) * D);
    chk(filt[7] == old, "R8 tick period early bound", int'(filt[7]), int'(old));
    idle(D);
    chk(filt[7] == ~old, "R8 tick period late bound", int'(filt[7]), int'(~old));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule